// File: doc/BRIEF.md
# PC Card Bus Cycle Timing Controller

This block turns one request into the strobe sequence for a card slot on an external bus. A request carries an address, a read/write flag, a single-or-burst flag, a three-bit space type, an area bit and a timing-set select. Two timing sets are kept on input pins. Each set holds a base wait count, a coarse low-speed extension, a setup stretch and a hold stretch. Two idle counts sit beside them, one for each area. All of these values are captured when the request is accepted and are held until the access ends.

Every beat runs through the same phases. First the address, chip select, card enables and the attribute/I-O select are driven for the setup time. Then the read or write strobe is held low. Then the bus stays valid for the hold time. A burst moves 32 bytes without letting go of chip select. Its first beat goes to the requested address, and the following beats step through the aligned 32-byte block and wrap at its end. When the access is over, an idle gap holds off the next request. A request that carries the reserved space code starts no bus cycle and raises an error pulse.

Top module: `pcc_timing_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no request, cs_n, ce1_n, ce2_n, reg_n, rd_n and we_n are all high, req_ready is high, and beat_ack and req_err are low.
- R2: A request is accepted on a clock edge with req_ready high and req_valid high. cs_n, ce1_n and bus_addr become active on the accepting edge. The strobe of the first beat falls exactly S cycles later, where S is the 4-bit setup field of the selected set (0 to 15).
- R3: The strobe of each beat stays low for base + extra + 1 cycles. base is the 3-bit wait field of the selected set. extra is 0, 15, 30 or 50 for low-speed codes 00, 01, 10 and 11.
- R4: After the strobe of the last beat rises, cs_n, the card enables, reg_n and bus_addr stay active for exactly H more cycles, where H is the 4-bit hold field of the selected set (0 to 15).
- R5: req_ready returns exactly I cycles after cs_n rises. I is idle_a when req_area is 0 and idle_b when req_area is 1, each a 3-bit count.
- R6: req_set = 0 takes the wait, low-speed, setup and hold fields from set A, and req_set = 1 takes them from set B.
- R7: Space codes: 001 is I/O with dynamic sizing, 010/011 are 8/16-bit I/O, 100/101 are 8/16-bit common memory, and 110/111 are 8/16-bit attribute memory. reg_n is low during the access for the I/O and attribute codes and high for the common codes. ce2_n is low only for 16-bit accesses, which are the codes 011, 101 and 111, and code 001 when card_is16 is 1.
- R8: A request with space code 000 produces a one-cycle req_err pulse on the accepting edge. No strobe, chip select or card enable becomes active, and req_ready stays high.
- R9: A burst request moves 32 beats at 8-bit width or 16 beats at 16-bit width. The first beat uses the requested address. Each later beat adds 1 (8-bit) or 2 (16-bit) to the low five address bits, modulo 32, and leaves the upper bits unchanged. cs_n stays low for the whole burst. Between beats the strobe is high for H + S cycles, or for 1 cycle if that sum is 0.
- R10: rd_n is the strobe for reads (req_write = 0) and we_n is the strobe for writes. The two are never low together. beat_ack is high for exactly one cycle for each beat, in the first cycle after that beat's strobe rises.
- R11: Changes on the timing, area, space and card_is16 inputs after a request has been accepted have no effect on that access or burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_addr | input | AW | Start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = 32-byte wrapping burst |
| req_area | input | 1 | Area select for idle count |
| req_set | input | 1 | Timing set select |
| req_space | input | 3 | Space type code |
| card_is16 | input | 1 | Card reports 16-bit port (code 001 only) |
| tma_wait | input | 3 | Set A base wait |
| tma_slow | input | 2 | Set A low-speed code |
| tma_setup | input | 4 | Set A setup cycles |
| tma_hold | input | 4 | Set A hold cycles |
| tmb_wait | input | 3 | Set B base wait |
| tmb_slow | input | 2 | Set B low-speed code |
| tmb_setup | input | 4 | Set B setup cycles |
| tmb_hold | input | 4 | Set B hold cycles |
| idle_a | input | 3 | Idle cycles after an area-0 access |
| idle_b | input | 3 | Idle cycles after an area-1 access |
| bus_addr | output | AW | Bus address |
| cs_n | output | 1 | Chip select, active low |
| ce1_n | output | 1 | Low card enable, active low |
| ce2_n | output | 1 | High card enable, active low |
| reg_n | output | 1 | Attribute/I-O select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| beat_ack | output | 1 | One-cycle pulse per completed beat |
| req_err | output | 1 | One-cycle pulse for a reserved space code |

## Verification
All outputs come from flops, so every phase starts on a clock edge. Chip select drops on the accepting edge. The strobe falls S edges later and rises base+extra+1 edges after that. Chip select rises H edges later and req_ready returns I edges after that. beat_ack and req_err appear on the same edge as the event that causes them. The monitor samples on falling edges and timestamps each transition. It compares the measured intervals and the address seen at each strobe with the items the driver queued when it issued the request, so timing faults and address faults both show up as a wrong interval or a wrong value.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_GAP
   } pcc_state_e;

   typedef struct packed {
      logic [2:0] base;
      logic [1:0] slow;
      logic [3:0] setup;
      logic [3:0] hold;
   } pcc_tim_t;

endpackage

// File: rtl/pcc_cfg_sel.sv
module pcc_cfg_sel
   import pcc_pkg::*;
#(
   parameter int EXTRA1 = 15,
   parameter int EXTRA2 = 30,
   parameter int EXTRA3 = 50,
   parameter int CNT_W  = 6
) (
   input  pcc_tim_t         set_a,
   input  pcc_tim_t         set_b,
   input  logic             sel,
   output logic [3:0]       setup,
   output logic [3:0]       hold,
   output logic [CNT_W-1:0] wtot
);

   pcc_tim_t         cur;
   logic [CNT_W-1:0] extra;

   assign cur = sel ? set_b : set_a;

   always_comb begin
      case (cur.slow)
         2'd1:    extra = CNT_W'(EXTRA1);
         2'd2:    extra = CNT_W'(EXTRA2);
         2'd3:    extra = CNT_W'(EXTRA3);
         default: extra = '0;
      endcase
   end

   assign setup = cur.setup;
   assign hold  = cur.hold;
   assign wtot  = CNT_W'(cur.base) + extra + CNT_W'(1);

endmodule

// File: rtl/pcc_space_dec.sv
module pcc_space_dec (
   input  logic [2:0] space,
   input  logic       card_is16,
   output logic       legal,
   output logic       is16,
   output logic       reg_on
);

   assign legal  = (space != 3'b000);
   assign is16   = (space == 3'b001) ? card_is16 : space[0];
   assign reg_on = (space[2:1] != 2'b10);

endmodule

// File: rtl/pcc_addr_seq.sv
module pcc_addr_seq #(
   parameter int AW        = 26,
   parameter int BLK_BYTES = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] start,
   input  logic          burst,
   input  logic          is16,
   output logic [AW-1:0] addr,
   output logic          last
);

   localparam int OFS_W = $clog2(BLK_BYTES);

   logic [AW-1:0]    addr_q;
   logic [OFS_W-1:0] left_q;
   logic [OFS_W-1:0] inc;

   generate
      if (AW <= OFS_W) begin : g_bad_aw
         $error("address narrower than the burst block");
      end
   endgenerate

   assign inc = is16 ? OFS_W'(2) : OFS_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load) begin
         addr_q <= start;
         if (!burst)    left_q <= '0;
         else if (is16) left_q <= OFS_W'(BLK_BYTES / 2 - 1);
         else           left_q <= OFS_W'(BLK_BYTES - 1);
      end else if (step) begin
         addr_q[OFS_W-1:0] <= addr_q[OFS_W-1:0] + inc;
         left_q            <= left_q - OFS_W'(1);
      end
   end

   assign addr = addr_q;
   assign last = (left_q == '0);

endmodule

// File: rtl/pcc_timing_ctrl.sv
module pcc_timing_ctrl
   import pcc_pkg::*;
#(
   parameter int AW        = 26,
   parameter int BLK_BYTES = 32,
   parameter int EXTRA1    = 15,
   parameter int EXTRA2    = 30,
   parameter int EXTRA3    = 50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic          req_burst,
   input  logic          req_area,
   input  logic          req_set,
   input  logic [2:0]    req_space,
   input  logic          card_is16,
   input  logic [2:0]    tma_wait,
   input  logic [1:0]    tma_slow,
   input  logic [3:0]    tma_setup,
   input  logic [3:0]    tma_hold,
   input  logic [2:0]    tmb_wait,
   input  logic [1:0]    tmb_slow,
   input  logic [3:0]    tmb_setup,
   input  logic [3:0]    tmb_hold,
   input  logic [2:0]    idle_a,
   input  logic [2:0]    idle_b,
   output logic [AW-1:0] bus_addr,
   output logic          cs_n,
   output logic          ce1_n,
   output logic          ce2_n,
   output logic          reg_n,
   output logic          rd_n,
   output logic          we_n,
   output logic          beat_ack,
   output logic          req_err
);

   localparam int WMAX  = 7 + EXTRA3 + 1;
   localparam int CNT_W = $clog2(WMAX + 1);

   generate
      if (!(EXTRA1 <= EXTRA2 && EXTRA2 <= EXTRA3)) begin : g_bad_extra
         $error("low-speed extensions must not decrease");
      end
      if (WMAX < 16) begin : g_bad_cnt
         $error("counter too narrow for setup and hold");
      end
      if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < 4) begin : g_bad_blk
         $error("burst block must be a power of two of at least 4");
      end
   endgenerate

   pcc_state_e       state_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   pcc_tim_t         set_a, set_b;
   logic [3:0]       in_setup, in_hold;
   logic [CNT_W-1:0] in_wtot;
   logic             sp_legal, sp_is16, sp_reg;

   logic [3:0]       lat_setup, lat_hold;
   logic [CNT_W-1:0] lat_wtot;
   logic [2:0]       lat_idle;
   logic             lat_wr, lat_is16, lat_reg;

   logic             capture, step, do_after, ack_d, err_d;
   logic             eff_is16, eff_wr, eff_reg, seq_last;
   logic             act_d, stb_d;

   assign set_a = '{base: tma_wait, slow: tma_slow, setup: tma_setup, hold: tma_hold};
   assign set_b = '{base: tmb_wait, slow: tmb_slow, setup: tmb_setup, hold: tmb_hold};

   pcc_cfg_sel #(
      .EXTRA1 (EXTRA1),
      .EXTRA2 (EXTRA2),
      .EXTRA3 (EXTRA3),
      .CNT_W  (CNT_W)
   ) u_cfg (
      .set_a  (set_a),
      .set_b  (set_b),
      .sel    (req_set),
      .setup  (in_setup),
      .hold   (in_hold),
      .wtot   (in_wtot)
   );

   pcc_space_dec u_dec (
      .space     (req_space),
      .card_is16 (card_is16),
      .legal     (sp_legal),
      .is16      (sp_is16),
      .reg_on    (sp_reg)
   );

   assign eff_is16 = capture ? sp_is16   : lat_is16;
   assign eff_wr   = capture ? req_write : lat_wr;
   assign eff_reg  = capture ? sp_reg    : lat_reg;

   pcc_addr_seq #(
      .AW        (AW),
      .BLK_BYTES (BLK_BYTES)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (capture),
      .step  (step),
      .start (req_addr),
      .burst (req_burst),
      .is16  (eff_is16),
      .addr  (bus_addr),
      .last  (seq_last)
   );

   always_comb begin
      st_d     = state_q;
      cnt_d    = cnt_q;
      capture  = 1'b0;
      step     = 1'b0;
      do_after = 1'b0;
      ack_d    = 1'b0;
      err_d    = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (!sp_legal) begin
                  err_d = 1'b1;
               end else begin
                  capture = 1'b1;
                  if (in_setup != 4'd0) begin
                     st_d  = ST_SETUP;
                     cnt_d = CNT_W'(in_setup) - CNT_W'(1);
                  end else begin
                     st_d  = ST_STROBE;
                     cnt_d = in_wtot - CNT_W'(1);
                  end
               end
            end
         end
         ST_SETUP: begin
            if (cnt_q == '0) begin
               st_d  = ST_STROBE;
               cnt_d = lat_wtot - CNT_W'(1);
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         ST_STROBE: begin
            if (cnt_q == '0) begin
               ack_d = 1'b1;
               if (lat_hold != 4'd0) begin
                  st_d  = ST_HOLD;
                  cnt_d = CNT_W'(lat_hold) - CNT_W'(1);
               end else begin
                  do_after = 1'b1;
               end
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
         ST_HOLD: begin
            if (cnt_q == '0) do_after = 1'b1;
            else             cnt_d = cnt_q - CNT_W'(1);
         end
         ST_GAP: begin
            if (cnt_q == '0) st_d = ST_IDLE;
            else             cnt_d = cnt_q - CNT_W'(1);
         end
         default: st_d = ST_IDLE;
      endcase

      if (do_after) begin
         if (!seq_last) begin
            step = 1'b1;
            if (lat_setup != 4'd0) begin
               st_d  = ST_SETUP;
               cnt_d = CNT_W'(lat_setup) - CNT_W'(1);
            end else if (lat_hold == 4'd0) begin
               st_d  = ST_SETUP;
               cnt_d = '0;
            end else begin
               st_d  = ST_STROBE;
               cnt_d = lat_wtot - CNT_W'(1);
            end
         end else if (lat_idle != 3'd0) begin
            st_d  = ST_GAP;
            cnt_d = CNT_W'(lat_idle) - CNT_W'(1);
         end else begin
            st_d  = ST_IDLE;
         end
      end
   end

   assign act_d = (st_d == ST_SETUP) || (st_d == ST_STROBE) || (st_d == ST_HOLD);
   assign stb_d = (st_d == ST_STROBE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         lat_setup <= '0;
         lat_hold  <= '0;
         lat_wtot  <= '0;
         lat_idle  <= '0;
         lat_wr    <= 1'b0;
         lat_is16  <= 1'b0;
         lat_reg   <= 1'b0;
         req_ready <= 1'b1;
         cs_n      <= 1'b1;
         ce1_n     <= 1'b1;
         ce2_n     <= 1'b1;
         reg_n     <= 1'b1;
         rd_n      <= 1'b1;
         we_n      <= 1'b1;
         beat_ack  <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         state_q <= st_d;
         cnt_q   <= cnt_d;
         if (capture) begin
            lat_setup <= in_setup;
            lat_hold  <= in_hold;
            lat_wtot  <= in_wtot;
            lat_idle  <= req_area ? idle_b : idle_a;
            lat_wr    <= req_write;
            lat_is16  <= sp_is16;
            lat_reg   <= sp_reg;
         end
         req_ready <= (st_d == ST_IDLE);
         cs_n      <= !act_d;
         ce1_n     <= !act_d;
         ce2_n     <= !(act_d && eff_is16);
         reg_n     <= !(act_d && eff_reg);
         rd_n      <= !(stb_d && !eff_wr);
         we_n      <= !(stb_d && eff_wr);
         beat_ack  <= ack_d;
         req_err   <= err_d;
      end
   end

endmodule

// File: rtl/pcc_timing_chk.sv
module pcc_timing_chk #(
   parameter int AW = 26
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic [AW-1:0] bus_addr,
   input logic          cs_n,
   input logic          ce2_n,
   input logic          reg_n,
   input logic          rd_n,
   input logic          we_n,
   input logic          beat_ack,
   input logic          req_err
);

   AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !we_n)); // R10

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !we_n) |-> !cs_n); // R2

   AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (cs_n && req_ready)); // R8

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((!rd_n || !we_n) && $past(!rd_n || !we_n)) |-> $stable(bus_addr)); // R9

   AST_SPACE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n)) |-> ($stable(reg_n) && $stable(ce2_n))); // R7

   AST_ACK_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      beat_ack |-> (rd_n && we_n && $past(!rd_n || !we_n))); // R10

   AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> cs_n); // R5

endmodule

bind pcc_timing_ctrl pcc_timing_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .bus_addr  (bus_addr),
   .cs_n      (cs_n),
   .ce2_n     (ce2_n),
   .reg_n     (reg_n),
   .rd_n      (rd_n),
   .we_n      (we_n),
   .beat_ack  (beat_ack),
   .req_err   (req_err)
);

// File: tb/pcc_timing_ctrl_tb.sv
module pcc_timing_ctrl_tb;

   localparam int AW = 26;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0, req_burst = 1'b0, req_area = 1'b0, req_set = 1'b0;
   logic [2:0]    req_space = 3'd4;
   logic          card_is16 = 1'b0;
   logic [2:0]    tma_wait = '0, tmb_wait = '0, idle_a = '0, idle_b = '0;
   logic [1:0]    tma_slow = '0, tmb_slow = '0;
   logic [3:0]    tma_setup = '0, tma_hold = '0, tmb_setup = '0, tmb_hold = '0;
   logic [AW-1:0] bus_addr;
   logic          cs_n, ce1_n, ce2_n, reg_n, rd_n, we_n, beat_ack, req_err;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pcc_timing_ctrl #(.AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
      .req_area(req_area), .req_set(req_set), .req_space(req_space),
      .card_is16(card_is16),
      .tma_wait(tma_wait), .tma_slow(tma_slow), .tma_setup(tma_setup), .tma_hold(tma_hold),
      .tmb_wait(tmb_wait), .tmb_slow(tmb_slow), .tmb_setup(tmb_setup), .tmb_hold(tmb_hold),
      .idle_a(idle_a), .idle_b(idle_b), .bus_addr(bus_addr), .cs_n(cs_n),
      .ce1_n(ce1_n), .ce2_n(ce2_n), .reg_n(reg_n), .rd_n(rd_n), .we_n(we_n),
      .beat_ack(beat_ack), .req_err(req_err)
   );

   typedef struct {
      logic [AW-1:0] addr;
      bit            wr;
      int            gap;
      int            width;
      bit            regn;
      bit            ce2n;
      string         tag;
   } beat_t;

   typedef struct {
      int    hold;
      int    idle;
      string tag;
   } end_t;

   beat_t bq[$];
   end_t  eq[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic set_cfg(input bit s, input int base, input int slow,
                          input int setup, input int hold);
      if (s) begin
         tmb_wait = 3'(base); tmb_slow = 2'(slow); tmb_setup = 4'(setup); tmb_hold = 4'(hold);
      end else begin
         tma_wait = 3'(base); tma_slow = 2'(slow); tma_setup = 4'(setup); tma_hold = 4'(hold);
      end
   endtask

   // Driver: issues one request and queues what the monitor must see.
   task automatic do_access(input bit wr, input bit burst, input bit area, input bit s,
                            input logic [2:0] space, input bit c16,
                            input logic [AW-1:0] addr, input bit scramble,
                            input string tag);
      int base, slow, su, hd, w, id, nb, stp, ext;
      bit is16;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      base = s ? tmb_wait : tma_wait;
      slow = s ? tmb_slow : tma_slow;
      su   = s ? tmb_setup : tma_setup;
      hd   = s ? tmb_hold : tma_hold;
      ext  = (slow == 0) ? 0 : (slow == 1) ? 15 : (slow == 2) ? 30 : 50;
      w    = base + ext + 1;
      id   = area ? idle_b : idle_a;
      is16 = (space == 3'b001) ? c16 : space[0];
      nb   = burst ? (is16 ? 16 : 32) : 1;
      stp  = is16 ? 2 : 1;
      for (int k = 0; k < nb; k++) begin
         beat_t b;
         b.addr  = {addr[AW-1:5], 5'(int'(addr[4:0]) + k * stp)};
         b.wr    = wr;
         b.gap   = (k == 0) ? su : ((su + hd == 0) ? 1 : su + hd);
         b.width = w;
         b.regn  = (space == 3'd4 || space == 3'd5);
         b.ce2n  = !is16;
         b.tag   = tag;
         bq.push_back(b);
      end
      eq.push_back('{hold: hd, idle: id, tag: tag});
      req_addr = addr; req_write = wr; req_burst = burst; req_area = area;
      req_set = s; req_space = space; card_is16 = c16; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (scramble) begin
         tma_wait = 3'd6; tma_slow = 2'd3; tma_setup = 4'd9; tma_hold = 4'd11;
         tmb_wait = 3'd1; tmb_slow = 2'd2; tmb_setup = 4'd13; tmb_hold = 4'd2;
         idle_a = 3'd7; idle_b = 3'd6; req_space = 3'd0; card_is16 = !c16;
         req_area = !area; req_set = !s; req_write = !wr;
      end
      while (bq.size() != 0 || eq.size() != 0) @(negedge clk);
   endtask

   // Monitor: timestamps transitions and compares against the queues.
   int t = 0, t_csf = 0, t_csr = 0, t_sf = 0, t_rise = 0;
   bit first = 1'b1, p_cs = 1'b1, p_stb = 1'b0, p_rdy = 1'b1;
   logic [AW-1:0] s_addr;
   bit s_wr, s_reg, s_ce2;

   always @(negedge clk) begin
      if (rst_n) begin
         bit stb;
         stb = !rd_n || !we_n;
         t++;
         if (p_cs && !cs_n) begin
            t_csf = t;
            first = 1'b1;
         end
         if (!p_stb && stb) begin
            t_sf   = t;
            s_addr = bus_addr;
            s_wr   = !we_n;
            s_reg  = reg_n;
            s_ce2  = ce2_n;
         end
         if (p_stb && !stb) begin
            if (bq.size() == 0) begin
               chk(1'b0, "R10", "unexpected beat", 0, 1);
            end else begin
               beat_t b;
               int gap;
               b = bq.pop_front();
               gap = first ? (t_sf - t_csf) : (t_sf - t_rise);
               chk(s_addr == b.addr, b.tag, "R9 beat address", s_addr, b.addr);
               chk(s_wr == b.wr, b.tag, "R10 strobe type", s_wr, b.wr);
               chk(gap == b.gap, b.tag, first ? "R2 setup" : "R9 inter-beat gap", gap, b.gap);
               chk((t - t_sf) == b.width, b.tag, "R3 R6 strobe width", t - t_sf, b.width);
               chk(s_reg == b.regn, b.tag, "R7 reg_n", s_reg, b.regn);
               chk(s_ce2 == b.ce2n, b.tag, "R7 ce2_n", s_ce2, b.ce2n);
               chk(beat_ack == 1'b1, b.tag, "R10 ack at strobe rise", beat_ack, 1);
            end
            t_rise = t;
            first  = 1'b0;
         end else if (beat_ack) begin
            chk(1'b0, "R10", "ack without strobe rise", 1, 0);
         end
         if (!p_cs && cs_n) t_csr = t;
         if (!p_rdy && req_ready) begin
            if (eq.size() == 0) begin
               chk(1'b0, "R5", "unexpected end", 0, 1);
            end else begin
               end_t e;
               e = eq.pop_front();
               chk((t_csr - t_rise) == e.hold, e.tag, "R4 hold", t_csr - t_rise, e.hold);
               chk((t - t_csr) == e.idle, e.tag, "R5 idle", t - t_csr, e.idle);
            end
         end
         p_cs  = cs_n;
         p_stb = stb;
         p_rdy = req_ready;
      end
   end

   task automatic check_idle_outputs(input string tag);
      chk({cs_n, ce1_n, ce2_n, reg_n, rd_n, we_n} == 6'h3f, tag, "strobes high",
          {cs_n, ce1_n, ce2_n, reg_n, rd_n, we_n}, 6'h3f);
      chk(req_ready == 1'b1, tag, "ready", req_ready, 1);
      chk({beat_ack, req_err} == 2'b00, tag, "ack/err low", {beat_ack, req_err}, 0);
   endtask

   task automatic do_reserved();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_space = 3'd0; req_addr = 26'h0000123; req_valid = 1'b1;
      @(negedge clk);
      chk(req_err == 1'b1, "R8", "error pulse", req_err, 1);
      chk(cs_n && rd_n && we_n && ce1_n, "R8", "no bus cycle", cs_n, 1);
      req_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(req_err == 1'b0, "R8", "pulse one cycle", req_err, 0);
         chk(cs_n && rd_n && we_n && req_ready, "R8", "stays idle",
             {cs_n, rd_n, we_n, req_ready}, 4'hf);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle_outputs("R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle_outputs("R1 after reset");

      set_cfg(0, 3, 0, 2, 1); set_cfg(1, 5, 1, 0, 0); idle_a = 3'd2; idle_b = 3'd5;
      do_access(0, 0, 0, 0, 3'd4, 0, 26'h0100040, 0, "R2 read setA");
      do_access(1, 0, 1, 1, 3'd5, 0, 26'h0100042, 0, "R6 write setB");
      set_cfg(0, 0, 2, 3, 4);
      do_access(0, 0, 0, 0, 3'd6, 0, 26'h0000007, 0, "R3 slow code 10");
      set_cfg(1, 7, 3, 1, 15);
      do_access(1, 0, 1, 1, 3'd7, 0, 26'h0000009, 0, "R3 slow code 11");
      set_cfg(0, 1, 0, 15, 0); idle_a = 3'd0;
      do_access(0, 0, 0, 0, 3'd1, 0, 26'h0000011, 0, "R7 dyn 8-bit");
      do_access(1, 0, 0, 0, 3'd1, 1, 26'h0000012, 0, "R7 dyn 16-bit");
      do_access(0, 0, 0, 0, 3'd2, 0, 26'h0000013, 0, "R7 io 8");
      do_access(1, 0, 0, 0, 3'd3, 0, 26'h0000014, 0, "R7 io 16");
      set_cfg(0, 2, 0, 1, 2); idle_a = 3'd3;
      do_access(0, 1, 0, 0, 3'd2, 0, 26'h03ABC1D, 0, "R9 burst 8-bit wrap");
      set_cfg(1, 1, 0, 0, 0); idle_b = 3'd1;
      do_access(1, 1, 1, 1, 3'd5, 0, 26'h0123456, 0, "R9 burst 16-bit min gap");
      set_cfg(0, 4, 1, 2, 3); idle_a = 3'd4;
      do_access(0, 0, 0, 0, 3'd4, 0, 26'h0000100, 1, "R11 single scrambled");
      set_cfg(1, 2, 0, 3, 1); idle_b = 3'd2;
      do_access(1, 1, 1, 1, 3'd7, 0, 26'h0000F0A, 1, "R11 burst scrambled");
      do_reserved();
      repeat (2) @(negedge clk);
      check_idle_outputs("R1 final");

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule